// File: doc/BRIEF.md
# Scan Chain with Held Functional Outputs

This block is a serial scan chain made of scan-hold cells. Each cell has a multiplexed flip-flop, which captures either its functional input or the serial bit from the cell before it. Behind the flip-flop sits a hold stage that drives the output toward the downstream logic.

While the hold control is high, every functional output keeps the value it had before hold went high. Meanwhile the flip-flops keep shifting or capturing underneath. The logic fed by the chain therefore sees no toggling during a scan load or unload.

The raw flip-flop output of each cell is the serial input of the next cell. The raw output of the last cell is the chain's scan-out. There is one clock and a synchronous, active-high reset. The scan and hold controls are plain level pins. The chain has no streaming interface, so it carries no valid/ready handshake and no back-pressure.

Top module: `shold_chain`

## Requirements
- R1: With `test_en` low (functional mode), every flip-flop loads its bit of `func_d` at the clock edge.
- R2: With `test_en` high (scan mode), cell 0 loads `scan_in` at the edge, and cell i loads the raw value of cell i-1. Data moves from bit 0 toward bit LEN-1.
- R3: At any edge where `hold` is high and reset is low, no bit of `func_q` changes, whatever the mode and the data.
- R4: At any edge where `hold` is low, each bit of `func_q` takes the same new value as its flip-flop. The outputs therefore follow the flip-flops again from the first edge after hold drops.
- R5: `scan_out` is the raw value of cell LEN-1. After a functional capture, a shift presents the captured `func_d` bits at `scan_out` in order from bit LEN-1 down to bit 0, one bit per edge.
- R6: A synchronous `rst` high at an edge clears every flip-flop and every held output to 0, even while `hold` is high.
- R7: When `hold` is high in functional mode, the flip-flops still capture `func_d` while `func_q` stays frozen. The newly captured data reaches `func_q` at the first edge with `hold` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| test_en | input | 1 | 1 = shift (scan mode), 0 = capture functional data |
| hold | input | 1 | 1 = freeze the functional outputs |
| scan_in | input | 1 | Serial input of cell 0 |
| func_d | input | LEN | Functional input of each cell |
| func_q | output | LEN | Held functional output of each cell |
| scan_out | output | 1 | Raw flip-flop value of the last cell |

## Verification
The bench shifts a full chain length with hold high. It checks that `func_q` never moves while the pattern leaves through `scan_out` in bit order. A design that fed the hold stage from the serial path, or that forgot to gate it, would show the outputs toggling during the shift.

The bench also releases hold after a frozen functional capture. A cell that sampled the held value instead of the flip-flop would show stale data, and a hold stage that lagged by one register would show the new data one edge late.

Reset is applied with hold high. A reset that did not have priority would leave the outputs at their old values.

// File: rtl/shold_pkg.sv
package shold_pkg;
  localparam int unsigned CHAIN_LEN_DEF = 8;

  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_SCAN = 1'b1
  } shold_mode_e;
endpackage

// File: rtl/shold_ff.sv
module shold_ff
  import shold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic test_en,
  input  logic d,
  input  logic sd,
  output logic nxt,
  output logic q
);
  shold_mode_e mode;

  assign mode = shold_mode_e'(test_en);

  always_comb begin
    if (rst)                    nxt = 1'b0;
    else if (mode == MODE_SCAN) nxt = sd;
    else                        nxt = d;
  end

  always_ff @(posedge clk) q <= nxt;

  p_func_cap_r1: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> q == $past(d));
  p_scan_load_r2: assert property (@(posedge clk) disable iff (rst)
    test_en |=> q == $past(sd));
endmodule

// File: rtl/shold_hold.sv
module shold_hold (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic nxt,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (!hold) q <= nxt;
  end

  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q));
  p_reset_r6: assert property (@(posedge clk)
    rst |=> q == 1'b0);
endmodule

// File: rtl/shold_cell.sv
module shold_cell (
  input  logic clk,
  input  logic rst,
  input  logic test_en,
  input  logic hold,
  input  logic d,
  input  logic sd,
  output logic raw_q,
  output logic func_q
);
  logic nxt;

  shold_ff u_ff (
    .clk     (clk),
    .rst     (rst),
    .test_en (test_en),
    .d       (d),
    .sd      (sd),
    .nxt     (nxt),
    .q       (raw_q)
  );

  shold_hold u_hold (
    .clk  (clk),
    .rst  (rst),
    .hold (hold),
    .nxt  (nxt),
    .q    (func_q)
  );

  p_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !hold |=> func_q == raw_q);
  p_hold_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (hold && !test_en) |=> raw_q == $past(d) && $stable(func_q));
endmodule

// File: rtl/shold_chain.sv
module shold_chain #(
  parameter int unsigned LEN = shold_pkg::CHAIN_LEN_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           test_en,
  input  logic           hold,
  input  logic           scan_in,
  input  logic [LEN-1:0] func_d,
  output logic [LEN-1:0] func_q,
  output logic           scan_out
);
  localparam int unsigned LAST = LEN - 1;

  logic [LEN-1:0] raw;
  logic [LEN:0]   ser;

  assign ser[0] = scan_in;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    shold_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .test_en (test_en),
      .hold    (hold),
      .d       (func_d[i]),
      .sd      (ser[i]),
      .raw_q   (raw[i]),
      .func_q  (func_q[i])
    );
    assign ser[i+1] = raw[i];
  end

  assign scan_out = ser[LEN];

  p_outs_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(func_q));
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> func_q == '0 && scan_out == 1'b0);

  if (LEN > 1) begin : g_sochk
    p_scanout_r5: assert property (@(posedge clk) disable iff (rst)
      test_en |=> scan_out == $past(raw[LAST-1]));
  end else begin : g_sochk1
    p_scanout_r5: assert property (@(posedge clk) disable iff (rst)
      test_en |=> scan_out == $past(scan_in));
  end
endmodule

// File: tb/shold_chain_bench.sv
module shold_chain_bench;
  localparam int N          = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, test_en, hold, scan_in;
  logic [N-1:0] func_d, func_q;
  logic scan_out;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  logic [N-1:0] m_ff, m_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  shold_chain #(.LEN(N)) u_shold_chain (
    .clk(clk), .rst(rst), .test_en(test_en), .hold(hold),
    .scan_in(scan_in), .func_d(func_d), .func_q(func_q), .scan_out(scan_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got=%0d expected<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step();
    logic [N-1:0] nxt;
    if (rst)          nxt = '0;
    else if (test_en) nxt = {m_ff[N-2:0], scan_in};
    else              nxt = func_d;
    if (rst || !hold) m_q = nxt;
    m_ff = nxt;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1; test_en = 0; hold = 1; scan_in = 0; func_d = '1;
    m_ff = '1; m_q = '1;
    step(); step();
    chk("R6 reset func_q", func_q, '0);
    chk("R6 reset scan_out", {7'd0, scan_out}, '0);
    rst = 0; hold = 0;
  endtask

  task automatic t_capture(logic [N-1:0] v);
    test_en = 0; hold = 0; func_d = v;
    step();
    chk("R1 R4 capture", func_q, v);
    chk("R5 scan_out msb", {7'd0, scan_out}, {7'd0, v[N-1]});
  endtask

  task automatic t_shift_hold(logic [N-1:0] v, logic [N-1:0] pat);
    t_capture(v);
    test_en = 1; hold = 1; func_d = ~v;
    for (int k = 0; k < N; k++) begin
      chk("R5 serial out", {7'd0, scan_out}, {7'd0, v[N-1-k]});
      scan_in = pat[N-1-k];
      step();
      chk("R3 frozen during shift", func_q, v);
    end
    test_en = 0; hold = 0; func_d = m_ff;
    test_en = 1; hold = 0; scan_in = 0;
    step();
    chk("R2 R4 release shows shifted", func_q, {pat[N-2:0], 1'b0});
    chk("R2 model", func_q, m_q);
  endtask

  task automatic t_hold_func();
    t_capture(8'h3C);
    test_en = 0; hold = 1; func_d = 8'hC1;
    step();
    chk("R7 frozen while capturing", func_q, 8'h3C);
    chk("R7 flop captured (scan_out)", {7'd0, scan_out}, 8'h01);
    func_d = 8'h55;
    step();
    chk("R7 still frozen", func_q, 8'h3C);
    hold = 0; func_d = 8'h9A;
    step();
    chk("R7 R4 released", func_q, 8'h9A);
  endtask

  task automatic t_shift_follow();
    t_capture(8'h81);
    test_en = 1; hold = 0; scan_in = 1;
    step();
    chk("R4 follow shift 1", func_q, 8'h03);
    scan_in = 0;
    step();
    chk("R4 follow shift 2", func_q, 8'h06);
    chk("R2 model", func_q, m_q);
  endtask

  task automatic t_reset_hold();
    t_capture(8'hF0);
    hold = 1; rst = 1;
    step();
    chk("R6 reset beats hold", func_q, 8'h00);
    rst = 0; hold = 0;
    step();
    chk("R6 after reset", func_q, m_q);
  endtask

  initial begin
    t_reset();
    t_capture(8'hA5);
    t_capture(8'h5A);
    t_shift_hold(8'hA5, 8'h96);
    t_shift_hold(8'h0F, 8'hE1);
    t_hold_func();
    t_shift_follow();
    t_reset_hold();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule